// File: doc/BRIEF.md
# Gated Clock Fanout Controller

This block holds the control side of a one-to-eight clock fanout. A single reference clock enters, and eight output pairs leave it. Each pair has a true line and a complement line. The pair for a lane runs when two conditions hold at once: its asynchronous active-low enable pin is low, and its enable bit in a small control register is set. When a lane is stopped, both of its lines rest low. Starting or stopping a lane never produces a shortened pulse on either line. Output frequency is always the reference frequency.

A single power-good input has two jobs. Its first high level after reset captures the frequency-select strap, and the captured value is held from then on. After that first high, a low level on the same input becomes a power-down request. The request takes effect only after it has been sampled low on two rising clock edges in a row. Once qualified, every lane is stopped at the falling edge that follows. When the input returns high, all lanes start again on a clean boundary and follow their own enables. The enable bits are loaded through a one-cycle write strobe.

All asynchronous inputs pass through two-flop synchronizers clocked by the reference clock. Lane enables change only on a falling edge, while the clock is low. Each complement line takes its enable half a cycle later, while that line is low.

Top module: `clk_fanout_ctrl`

## Requirements
- R1: After reset every register enable bit is 1, the captured strap reads 0, and every output line stays low until the power-good input has been high.
- R2: Once power-good has been high and no power-down is active, lane i runs exactly when enable pin bit i is 0 and register bit i is 1.
- R3: A lane that is not running holds both its true and complement lines at 0.
- R4: A running lane's true line equals the reference clock, and its complement line is its inverse, so there is one output rising edge for each reference rising edge.
- R5: Every high pulse on any output line lasts a full half reference period, including across enable, disable, power-down and restart transitions.
- R6: The first rising level of power-good after reset captures the frequency-select strap onto the strap output; later strap changes leave that output unchanged until the next reset.
- R7: After the first power-good high, power-good sampled low on two consecutive rising edges stops all lanes. A low that covers only one sample stops nothing.
- R8: When power-good returns high after a power-down, lanes restart and again follow R2.
- R9: A write strobe high on a rising edge loads the write data into the register enable bits, bit i controlling lane i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Reference clock |
| rst_i | input | 1 | Synchronous active-high reset |
| oe_n_i | input | NOUT | Asynchronous active-low per-lane enable pins |
| pwrgd_i | input | 1 | Power-good and, after its first high, active-low power-down request |
| fsel_strap_i | input | 1 | Frequency-select strap |
| wr_en_i | input | 1 | Write strobe for the enable register |
| wr_data_i | input | NOUT | Write data, one enable bit per lane |
| clk_p_o | output | NOUT | Gated true clock lines |
| clk_n_o | output | NOUT | Gated complement clock lines |
| fsel_o | output | 1 | Captured frequency-select strap |

## Verification
The gating is tried with pin-only masks, register-only masks and mixed masks whose AND differs from either operand. A failure there shows whether the two enable sources combine, or whether one of them is ignored. Enable pins are also toggled at offsets unrelated to the clock, while every output pulse width is measured. This separates gating done on the low phase from gating applied directly. Power-good is driven with a long low and with a low that covers exactly one sample, which tests the two-sample qualification. The strap is moved after capture and again across a power-down, which shows that it is held.

// File: rtl/cfo_pkg.sv
package cfo_pkg;

    typedef enum logic [1:0] {
        PWR_WAIT = 2'd0,
        PWR_RUN  = 2'd1,
        PWR_DOWN = 2'd2
    } pwr_state_e;

    typedef struct packed {
        pwr_state_e state;
        logic       held;
        logic       strap;
    } pwr_ctx_t;

    localparam pwr_ctx_t PWR_CTX_RESET = '{state: PWR_WAIT, held: 1'b0, strap: 1'b0};

    function automatic logic lane_want(input logic pin_n, input logic reg_bit, input logic run);
        return run & reg_bit & ~pin_n;
    endfunction

endpackage

// File: rtl/cfo_sync.sv
module cfo_sync #(
    parameter int unsigned WIDTH  = 1,
    parameter int unsigned STAGES = 2
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic [WIDTH-1:0] d_i,
    input  logic [WIDTH-1:0] rst_val_i,
    output logic [WIDTH-1:0] q_o
);
    logic [WIDTH-1:0] stage_q [STAGES];

    generate
        for (genvar s = 0; s < STAGES; s++) begin : g_stage
            always_ff @(posedge clk_i) begin
                if (rst_i) begin
                    stage_q[s] <= rst_val_i;
                end else if (s == 0) begin
                    stage_q[s] <= d_i;
                end else begin
                    stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
                end
            end
        end
    endgenerate

    assign q_o = stage_q[STAGES-1];
endmodule

// File: rtl/cfo_pwr_ctrl.sv
module cfo_pwr_ctrl
    import cfo_pkg::*;
#(
    parameter int unsigned QUAL = 2
) (
    input  logic clk_i,
    input  logic rst_i,
    input  logic pg_sync_i,
    input  logic strap_i,
    output logic run_o,
    output logic held_o,
    output logic fsel_o
);
    localparam int unsigned CW = $clog2(QUAL + 1);
    localparam logic [CW-1:0] LAST_LOW = CW'(QUAL - 1);

    pwr_ctx_t        ctx_q;
    logic [CW-1:0]   low_q;

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            ctx_q <= PWR_CTX_RESET;
            low_q <= '0;
        end else begin
            unique case (ctx_q.state)
                PWR_WAIT: begin
                    low_q <= '0;
                    if (pg_sync_i) begin
                        ctx_q.state <= PWR_RUN;
                        ctx_q.held  <= 1'b1;
                        ctx_q.strap <= strap_i;
                    end
                end
                PWR_RUN: begin
                    if (pg_sync_i) begin
                        low_q <= '0;
                    end else if (low_q == LAST_LOW) begin
                        low_q       <= '0;
                        ctx_q.state <= PWR_DOWN;
                    end else begin
                        low_q <= low_q + 1'b1;
                    end
                end
                PWR_DOWN: begin
                    low_q <= '0;
                    if (pg_sync_i) begin
                        ctx_q.state <= PWR_RUN;
                    end
                end
                default: begin
                    ctx_q <= PWR_CTX_RESET;
                    low_q <= '0;
                end
            endcase
        end
    end

    assign run_o  = (ctx_q.state == PWR_RUN);
    assign held_o = ctx_q.held;
    assign fsel_o = ctx_q.strap;
endmodule

// File: rtl/cfo_gate_cell.sv
module cfo_gate_cell (
    input  logic clk_i,
    input  logic rst_i,
    input  logic want_i,
    output logic en_o,
    output logic p_o,
    output logic n_o
);
    logic en_q;
    logic en_n_q;

    // true-line enable moves while the clock is low
    always_ff @(negedge clk_i) begin
        if (rst_i) begin
            en_q <= 1'b0;
        end else begin
            en_q <= want_i;
        end
    end

    // complement-line enable moves while its line is low (clock high)
    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_n_q <= 1'b0;
        end else begin
            en_n_q <= en_q;
        end
    end

    assign en_o = en_q;
    assign p_o  = clk_i & en_q;
    assign n_o  = ~clk_i & en_n_q;
endmodule

// File: rtl/clk_fanout_ctrl.sv
module clk_fanout_ctrl
    import cfo_pkg::*;
#(
    parameter int unsigned NOUT        = 8,
    parameter int unsigned SYNC_STAGES = 2,
    parameter int unsigned PD_QUAL     = 2
) (
    input  logic            clk_i,
    input  logic            rst_i,
    input  logic [NOUT-1:0] oe_n_i,
    input  logic            pwrgd_i,
    input  logic            fsel_strap_i,
    input  logic            wr_en_i,
    input  logic [NOUT-1:0] wr_data_i,
    output logic [NOUT-1:0] clk_p_o,
    output logic [NOUT-1:0] clk_n_o,
    output logic            fsel_o
);
    localparam int unsigned SW = NOUT + 1;

    logic [SW-1:0]   sync_in;
    logic [SW-1:0]   sync_out;
    logic [SW-1:0]   sync_rst;
    logic [NOUT-1:0] oe_n_sync;
    logic            pg_sync;
    logic [NOUT-1:0] en_reg_q;
    logic [NOUT-1:0] gate_en;
    logic            pwr_run;
    logic            strap_held;

    assign sync_in  = {pwrgd_i, oe_n_i};
    assign sync_rst = {1'b0, {NOUT{1'b1}}};

    cfo_sync #(
        .WIDTH  (SW),
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .d_i       (sync_in),
        .rst_val_i (sync_rst),
        .q_o       (sync_out)
    );

    assign oe_n_sync = sync_out[NOUT-1:0];
    assign pg_sync   = sync_out[NOUT];

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            en_reg_q <= '1;
        end else if (wr_en_i) begin
            en_reg_q <= wr_data_i;
        end
    end

    cfo_pwr_ctrl #(
        .QUAL (PD_QUAL)
    ) u_pwr (
        .clk_i     (clk_i),
        .rst_i     (rst_i),
        .pg_sync_i (pg_sync),
        .strap_i   (fsel_strap_i),
        .run_o     (pwr_run),
        .held_o    (strap_held),
        .fsel_o    (fsel_o)
    );

    generate
        for (genvar i = 0; i < NOUT; i++) begin : g_lane
            cfo_gate_cell u_cell (
                .clk_i  (clk_i),
                .rst_i  (rst_i),
                .want_i (lane_want(oe_n_sync[i], en_reg_q[i], pwr_run)),
                .en_o   (gate_en[i]),
                .p_o    (clk_p_o[i]),
                .n_o    (clk_n_o[i])
            );
        end
    endgenerate
endmodule

// File: rtl/cfo_chk.sv
module cfo_chk #(
    parameter int unsigned NOUT = 8
) (
    input logic            clk_i,
    input logic            rst_i,
    input logic [NOUT-1:0] oe_n_sync,
    input logic [NOUT-1:0] en_reg_q,
    input logic [NOUT-1:0] gate_en,
    input logic            pg_sync,
    input logic            pwr_run,
    input logic            strap_held,
    input logic            fsel_o
);
    // R1
    wait_stopped_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        !strap_held |=> (gate_en == '0));

    // R2
    reg_gate_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        (en_reg_q != '1) |=> ((gate_en & ~$past(en_reg_q)) == '0));

    // R2
    pin_gate_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        (oe_n_sync != '0) |=> ((gate_en & $past(oe_n_sync)) == '0));

    // R6
    strap_hold_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (strap_held && $past(strap_held)) |-> $stable(fsel_o));

    // R7
    pd_qualify_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwr_run && $past(pwr_run) && !pg_sync && !$past(pg_sync)) |=> !pwr_run);

    // R7
    pd_single_chk: assert property (@(posedge clk_i) disable iff (rst_i)
        (pwr_run && pg_sync) |=> pwr_run);

    // R7
    pd_stop_chk: assert property (@(negedge clk_i) disable iff (rst_i)
        !pwr_run |=> (gate_en == '0));
endmodule

bind clk_fanout_ctrl cfo_chk #(.NOUT(NOUT)) u_cfo_chk (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .oe_n_sync  (oe_n_sync),
    .en_reg_q   (en_reg_q),
    .gate_en    (gate_en),
    .pg_sync    (pg_sync),
    .pwr_run    (pwr_run),
    .strap_held (strap_held),
    .fsel_o     (fsel_o)
);

// File: tb/tb_clk_fanout_ctrl.sv
module tb_clk_fanout_ctrl;
    localparam int NOUT = 8;
    localparam real HALF = 10.0;

    logic            clk_i = 1'b0;
    logic            rst_i = 1'b1;
    logic [NOUT-1:0] oe_n_i = '0;
    logic            pwrgd_i = 1'b0;
    logic            fsel_strap_i = 1'b0;
    logic            wr_en_i = 1'b0;
    logic [NOUT-1:0] wr_data_i = '0;
    logic [NOUT-1:0] clk_p_o;
    logic [NOUT-1:0] clk_n_o;
    logic            fsel_o;

    int checks = 0;
    int errors = 0;
    int short_cnt = 0;
    int p0_rises = 0;
    bit done = 0;

    clk_fanout_ctrl dut (
        .clk_i        (clk_i),
        .rst_i        (rst_i),
        .oe_n_i       (oe_n_i),
        .pwrgd_i      (pwrgd_i),
        .fsel_strap_i (fsel_strap_i),
        .wr_en_i      (wr_en_i),
        .wr_data_i    (wr_data_i),
        .clk_p_o      (clk_p_o),
        .clk_n_o      (clk_n_o),
        .fsel_o       (fsel_o)
    );

    always #10 clk_i = ~clk_i;

    // pulse-width monitors (R5) and rising-edge counter (R4)
    real             rise_p [NOUT];
    real             rise_n [NOUT];
    logic [NOUT-1:0] prev_p = '0;
    logic [NOUT-1:0] prev_n = '0;

    always @(clk_p_o) begin
        for (int i = 0; i < NOUT; i++) begin
            if (clk_p_o[i] === 1'b1 && prev_p[i] !== 1'b1) begin
                rise_p[i] = $realtime;
                if (i == 0) p0_rises++;
            end else if (clk_p_o[i] !== 1'b1 && prev_p[i] === 1'b1) begin
                if ($realtime - rise_p[i] < HALF - 0.5) short_cnt++;
            end
        end
        prev_p = clk_p_o;
    end

    always @(clk_n_o) begin
        for (int i = 0; i < NOUT; i++) begin
            if (clk_n_o[i] === 1'b1 && prev_n[i] !== 1'b1) begin
                rise_n[i] = $realtime;
            end else if (clk_n_o[i] !== 1'b1 && prev_n[i] === 1'b1) begin
                if ($realtime - rise_n[i] < HALF - 0.5) short_cnt++;
            end
        end
        prev_n = clk_n_o;
    end

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic step(input int n);
        repeat (n) @(posedge clk_i);
        #2;
    endtask

    // samples both phases: true lines = mask while high, complement = mask while low
    task automatic check_lanes(input string req, input logic [NOUT-1:0] mask);
        @(posedge clk_i); #5;
        check({req, " true/high"}, 32'(clk_p_o), 32'(mask));
        check({req, " comp/high"}, 32'(clk_n_o), 32'(0));
        @(negedge clk_i); #5;
        check({req, " true/low"}, 32'(clk_p_o), 32'(0));
        check({req, " comp/low"}, 32'(clk_n_o), 32'(mask));
        step(1);
    endtask

    task automatic write_reg(input logic [NOUT-1:0] v);
        wr_data_i = v;
        wr_en_i   = 1'b1;
        step(1);
        wr_en_i   = 1'b0;
    endtask

    task automatic t_reset;
        step(3);
        check("R1 strap after reset", 32'(fsel_o), 32'(0));
        check_lanes("R1 stopped before power-good", '0);
        step(4);
        check_lanes("R1 still stopped", '0);
    endtask

    task automatic t_powerup;
        fsel_strap_i = 1'b1;
        pwrgd_i      = 1'b1;
        step(8);
        check("R6 strap captured", 32'(fsel_o), 32'(1));
        check_lanes("R1 R4 all lanes run by default", '1);
    endtask

    task automatic t_frequency;
        int start;
        start = p0_rises;
        step(20);
        check("R4 one output edge per input edge", 32'(p0_rises - start), 32'(20));
    endtask

    task automatic t_strap_ignore;
        fsel_strap_i = 1'b0;
        step(6);
        check("R6 strap change ignored", 32'(fsel_o), 32'(1));
    endtask

    task automatic t_pin_gate;
        oe_n_i = 8'b1010_0101;
        step(6);
        check_lanes("R2 R3 pin mask", 8'b0101_1010);
        oe_n_i = '0;
        step(6);
    endtask

    task automatic t_reg_write;
        write_reg(8'b0011_1100);
        step(4);
        check_lanes("R9 R2 register mask", 8'b0011_1100);
        oe_n_i = 8'b0101_0101;
        write_reg(8'b0011_0011);
        step(6);
        check_lanes("R2 R3 pin AND register", 8'b0010_0010);
        oe_n_i = '0;
        write_reg('1);
        step(6);
    endtask

    task automatic t_glitch;
        for (int k = 0; k < 40; k++) begin
            #(3 + (k * 13) % 17);
            oe_n_i = NOUT'((k * 37 + 11) % 256);
        end
        oe_n_i = '0;
        step(6);
        check("R5 no short pulse under async toggling", 32'(short_cnt), 32'(0));
        check_lanes("R2 lanes back after toggling", '1);
    endtask

    task automatic t_short_pulse;
        pwrgd_i = 1'b0;
        step(1);
        pwrgd_i = 1'b1;
        for (int k = 0; k < 4; k++) begin
            check_lanes("R7 single low sample ignored", '1);
        end
    endtask

    task automatic t_powerdown;
        write_reg(8'b1100_0110);
        step(4);
        pwrgd_i = 1'b0;
        step(7);
        check_lanes("R7 R3 power-down stops all", '0);
        fsel_strap_i = 1'b0;
        step(3);
        check_lanes("R7 stays down", '0);
    endtask

    task automatic t_resume;
        pwrgd_i = 1'b1;
        step(7);
        check_lanes("R8 restart follows register", 8'b1100_0110);
        check("R6 strap kept across power cycle", 32'(fsel_o), 32'(1));
        check("R5 no short pulse on stop or restart", 32'(short_cnt), 32'(0));
    endtask

    initial begin
        step(5);
        rst_i = 1'b0;
        t_reset();
        t_powerup();
        t_frequency();
        t_strap_ignore();
        t_pin_gate();
        t_reg_write();
        t_glitch();
        t_short_pulse();
        t_powerdown();
        t_resume();
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk_i);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule